// File: doc/BRIEF.md
# Page-Table Walker for TLB Refill

This block services a translation miss by fetching the missing page-table entry from memory and turning it into a refill write for one of four replaceable TLB ways. When a miss is handed to it, the walker forms the virtual address of the page-table entry. The address is the page-table base ORed with the miss address shifted right by ten, with its two lowest bits forced to zero. The walker then asks the TLB to translate that address with a read at the most privileged ring. This lookup gets one chance only: if it misses, or if reads are not allowed, the walk gives up and no second walk is started for the table itself.

After a successful lookup the walker sends one read request to memory and waits for the reply. A good reply becomes a refill record with these fields:
- the virtual page and in-way slot index of the miss address;
- the physical page taken from the entry;
- the attribute nibble;
- an address-space identifier. The entry's two-bit ring field chooses one byte of the ring-identifier register, and that byte is the identifier.

The target way comes from a small counter. The counter steps forward before each use, so the first refill after reset goes to way 1. The miss address is copied into a fault-address register when a walk succeeds. A failed lookup or a memory error reports failure and changes no state.

Top module: `ptw_walker`

## Requirements
- R1: After reset `busy`, `done`, `fail`, `refill_we` and `mem_req` are 0 and `fault_vaddr` is 0.
- R2: The cycle after a miss is accepted, `xl_req` is 1 and `xl_vaddr` equals `(pte_base | (miss_vaddr >> 10)) & 32'hFFFF_FFFC`.
- R3: If in that cycle `xl_hit` is 0 or `xl_read_ok` is 0, `fail` pulses for one cycle in the next cycle. In that case no memory request is made, `busy` drops, and no other lookup is started.
- R4: On a good lookup, `mem_req` is 1 for exactly one cycle, in the next cycle, with `mem_addr` equal to the `xl_paddr` from the lookup cycle. No second request is issued before the reply.
- R5: A reply with `mem_resp_err` = 1 makes `fail` pulse in the next cycle, with no refill write.
- R6: A good reply makes `refill_we` and `done` high for one cycle, in the next cycle. In that cycle the refill fields are:
  - `refill_vpn` = miss address & 32'hFFFF_F000;
  - `refill_index` = miss address bits [13:12];
  - `refill_ppn` = entry & 32'hFFFF_F000;
  - `refill_attr` = entry bits [3:0];
  - `refill_asid` = byte r of `ring_asids` (bits 8r+7:8r), where r is entry bits [5:4];
  - `refill_is_fetch` = the access type of the miss.
- R7: `refill_way` comes from a counter that resets to 0 and is incremented modulo 4 before each refill (1, 2, 3, 0, ...). Failed walks do not advance it.
- R8: `fault_vaddr` takes the miss address in the cycle after a successful refill and is left unchanged by failed walks.
- R9: `miss_valid` is ignored while `busy` is 1, including in the refill-write cycle.
- R10: `busy` is 1 from the cycle after acceptance until the cycle after `done` or `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss presented for walking |
| miss_vaddr | input | 32 | Virtual address that missed |
| miss_is_fetch | input | 1 | 1 = instruction fetch miss, 0 = data miss |
| pte_base | input | 32 | Page-table base register |
| ring_asids | input | 32 | Four 8-bit ring identifiers, ring r in bits 8r+7:8r |
| xl_req | output | 1 | Lookup of the entry address is active |
| xl_vaddr | output | 32 | Virtual address of the page-table entry |
| xl_hit | input | 1 | Lookup hit (same cycle) |
| xl_read_ok | input | 1 | Ring-0 read allowed on the hit page |
| xl_paddr | input | 32 | Translated physical entry address |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Physical address of the read |
| mem_resp_valid | input | 1 | Read reply present |
| mem_resp_err | input | 1 | Read reply is an error |
| mem_rdata | input | 32 | Page-table entry read |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk ended with a refill |
| fail | output | 1 | Walk ended without a refill |
| refill_we | output | 1 | Refill write strobe |
| refill_is_fetch | output | 1 | Target TLB: 1 instruction, 0 data |
| refill_way | output | 2 | Way written |
| refill_index | output | 2 | Slot within the way |
| refill_vpn | output | 32 | Virtual page number |
| refill_ppn | output | 32 | Physical page number |
| refill_asid | output | 8 | Address-space identifier |
| refill_attr | output | 4 | Attribute nibble |
| fault_vaddr | output | 32 | Last successfully refilled miss address |

## Verification
In the refill-write cycle, a new miss can be presented in the same cycle as the refill write and the fault-address update. The bench provokes this by keeping `miss_valid` high, with a different address, from just after acceptance through the write cycle. It drops the request at the next falling edge and then expects `busy` low and `fault_vaddr` holding the walked address rather than the intruder's. A second collision is a reply that arrives in the same cycle as the request. The bench covers it by answering with zero latency and checking that the refill appears one cycle later and that no second request follows.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XLATE = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } ptw_state_e;
endpackage

// File: rtl/ptw_pte_addr.sv
// Forms the virtual address of the page-table entry for a miss address.
module ptw_pte_addr #(
  parameter int ADDR_W    = 32,
  parameter int PTE_SHIFT = 10,
  parameter int ALIGN_LSB = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] vaddr,
  output logic [ADDR_W-1:0] pte_va
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << ALIGN_LSB) - ADDR_W'(1));

  always_comb begin
    pte_va = (base | (vaddr >> PTE_SHIFT)) & ALIGN_MASK;
  end
endmodule

// File: rtl/ptw_victim_ctr.sv
// Round-robin victim selector: the counter is advanced before its value is used.
module ptw_victim_ctr #(
  parameter int WAYS = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [WAY_W-1:0] way_use
);
  logic [WAY_W-1:0] ctr_q;
  logic [WAY_W-1:0] ctr_inc;

  always_comb begin
    if (ctr_q == WAY_W'(WAYS - 1)) ctr_inc = '0;
    else                           ctr_inc = ctr_q + WAY_W'(1);
  end

  assign way_use = ctr_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
    end else if (advance) begin
      ctr_q <= ctr_inc;
    end
  end
endmodule

// File: rtl/ptw_entry_fmt.sv
// Turns a fetched page-table entry plus the miss address into refill fields.
module ptw_entry_fmt #(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int WAY_ENTRIES = 4,
  parameter int RING_CNT    = 4,
  parameter int ASID_W      = 8,
  parameter int ATTR_W      = 4,
  localparam int IDX_W  = (WAY_ENTRIES > 1) ? $clog2(WAY_ENTRIES) : 1,
  localparam int RING_W = (RING_CNT > 1) ? $clog2(RING_CNT) : 1
) (
  input  logic [ADDR_W-1:0]          pte,
  input  logic [ADDR_W-1:0]          vaddr,
  input  logic [RING_CNT*ASID_W-1:0] ring_ids,
  output logic [ADDR_W-1:0]          vpn,
  output logic [IDX_W-1:0]           index,
  output logic [ADDR_W-1:0]          ppn,
  output logic [ATTR_W-1:0]          attr,
  output logic [ASID_W-1:0]          asid
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1));

  logic [RING_W-1:0] ring;
  logic [ASID_W-1:0] ring_byte [RING_CNT];

  // Slice the ring-identifier register into one lane per ring.
  for (genvar g = 0; g < RING_CNT; g++) begin : g_ring_lane
    assign ring_byte[g] = ring_ids[g*ASID_W +: ASID_W];
  end

  always_comb begin
    ring  = pte[ATTR_W +: RING_W];
    vpn   = vaddr & PAGE_MASK;
    index = vaddr[PAGE_SHIFT +: IDX_W];
    ppn   = pte & PAGE_MASK;
    attr  = pte[ATTR_W-1:0];
    asid  = '0;
    for (int r = 0; r < RING_CNT; r++) begin
      if (ring == RING_W'(r)) asid = ring_byte[r];
    end
  end
endmodule

// File: rtl/ptw_walker.sv
// Refill walker: entry-address lookup, one memory read, one refill write.
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int PTE_SHIFT   = 10,
  parameter int REFILL_WAYS = 4,
  parameter int WAY_ENTRIES = 4,
  parameter int RING_CNT    = 4,
  parameter int ASID_W      = 8,
  parameter int ATTR_W      = 4,
  localparam int WAY_W = (REFILL_WAYS > 1) ? $clog2(REFILL_WAYS) : 1,
  localparam int IDX_W = (WAY_ENTRIES > 1) ? $clog2(WAY_ENTRIES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       miss_valid,
  input  logic [ADDR_W-1:0]          miss_vaddr,
  input  logic                       miss_is_fetch,
  input  logic [ADDR_W-1:0]          pte_base,
  input  logic [RING_CNT*ASID_W-1:0] ring_asids,
  output logic                       xl_req,
  output logic [ADDR_W-1:0]          xl_vaddr,
  input  logic                       xl_hit,
  input  logic                       xl_read_ok,
  input  logic [ADDR_W-1:0]          xl_paddr,
  output logic                       mem_req,
  output logic [ADDR_W-1:0]          mem_addr,
  input  logic                       mem_resp_valid,
  input  logic                       mem_resp_err,
  input  logic [ADDR_W-1:0]          mem_rdata,
  output logic                       busy,
  output logic                       done,
  output logic                       fail,
  output logic                       refill_we,
  output logic                       refill_is_fetch,
  output logic [WAY_W-1:0]           refill_way,
  output logic [IDX_W-1:0]           refill_index,
  output logic [ADDR_W-1:0]          refill_vpn,
  output logic [ADDR_W-1:0]          refill_ppn,
  output logic [ASID_W-1:0]          refill_asid,
  output logic [ATTR_W-1:0]          refill_attr,
  output logic [ADDR_W-1:0]          fault_vaddr
);
  ptw_state_e        state_q, state_d;
  logic [ADDR_W-1:0] miss_va_q;
  logic              fetch_q;
  logic [ADDR_W-1:0] pte_va_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic              mem_req_q;
  logic [ADDR_W-1:0] pte_q;
  logic              fail_q;
  logic [ADDR_W-1:0] fault_q;
  logic [ADDR_W-1:0] pte_va_d;

  // Clock enables and decision terms
  logic accept_miss;
  logic xl_good;
  logic xl_bad;
  logic rsp_good;
  logic rsp_bad;
  logic in_write;

  always_comb begin
    accept_miss = (state_q == ST_IDLE) && miss_valid;
    xl_good     = (state_q == ST_XLATE) && xl_hit && xl_read_ok;
    xl_bad      = (state_q == ST_XLATE) && !(xl_hit && xl_read_ok);
    rsp_good    = (state_q == ST_READ) && mem_resp_valid && !mem_resp_err;
    rsp_bad     = (state_q == ST_READ) && mem_resp_valid && mem_resp_err;
    in_write    = (state_q == ST_WRITE);
  end

  ptw_pte_addr #(
    .ADDR_W    (ADDR_W),
    .PTE_SHIFT (PTE_SHIFT),
    .ALIGN_LSB (2)
  ) u_pte_addr (
    .base   (pte_base),
    .vaddr  (miss_vaddr),
    .pte_va (pte_va_d)
  );

  ptw_victim_ctr #(
    .WAYS (REFILL_WAYS)
  ) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (in_write),
    .way_use (refill_way)
  );

  ptw_entry_fmt #(
    .ADDR_W      (ADDR_W),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .WAY_ENTRIES (WAY_ENTRIES),
    .RING_CNT    (RING_CNT),
    .ASID_W      (ASID_W),
    .ATTR_W      (ATTR_W)
  ) u_fmt (
    .pte      (pte_q),
    .vaddr    (miss_va_q),
    .ring_ids (ring_asids),
    .vpn      (refill_vpn),
    .index    (refill_index),
    .ppn      (refill_ppn),
    .attr     (refill_attr),
    .asid     (refill_asid)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_miss) state_d = ST_XLATE;
      ST_XLATE: state_d = xl_good ? ST_READ : ST_IDLE;
      ST_READ:  begin
        if (rsp_good)     state_d = ST_WRITE;
        else if (rsp_bad) state_d = ST_IDLE;
      end
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // State and control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mem_req_q <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      mem_req_q <= xl_good;
      fail_q    <= xl_bad || rsp_bad;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_va_q <= '0;
      fetch_q   <= 1'b0;
      pte_va_q  <= '0;
    end else if (accept_miss) begin
      miss_va_q <= miss_vaddr;
      fetch_q   <= miss_is_fetch;
      pte_va_q  <= pte_va_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr_q <= '0;
    end else if (xl_good) begin
      mem_addr_q <= xl_paddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pte_q <= '0;
    end else if (rsp_good) begin
      pte_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
    end else if (in_write) begin
      fault_q <= miss_va_q;
    end
  end

  // Outputs
  assign xl_req          = (state_q == ST_XLATE);
  assign xl_vaddr        = pte_va_q;
  assign mem_req         = mem_req_q;
  assign mem_addr        = mem_addr_q;
  assign busy            = (state_q != ST_IDLE);
  assign done            = in_write;
  assign refill_we       = in_write;
  assign fail            = fail_q;
  assign refill_is_fetch = fetch_q;
  assign fault_vaddr     = fault_q;
endmodule

// File: rtl/ptw_walker_chk.sv
// Protocol checker for the walker, attached by bind.
module ptw_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              busy,
  input logic              xl_req,
  input logic              xl_hit,
  input logic              xl_read_ok,
  input logic              mem_req,
  input logic              done,
  input logic              fail,
  input logic              refill_we,
  input logic [ADDR_W-1:0] fault_vaddr
);
  assert_accept_starts_lookup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !busy) |=> (busy && xl_req));

  assert_bad_lookup_fails_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && !(xl_hit && xl_read_ok)) |=> (fail && !mem_req));

  assert_single_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_refill_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    refill_we |=> (!refill_we && !busy));

  assert_done_fail_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  assert_fail_ends_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !busy);

  assert_fault_only_on_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !refill_we |=> $stable(fault_vaddr));
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .miss_valid  (miss_valid),
  .busy        (busy),
  .xl_req      (xl_req),
  .xl_hit      (xl_hit),
  .xl_read_ok  (xl_read_ok),
  .mem_req     (mem_req),
  .done        (done),
  .fail        (fail),
  .refill_we   (refill_we),
  .fault_vaddr (fault_vaddr)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        miss_valid;
  logic [31:0] miss_vaddr;
  logic        miss_is_fetch;
  logic [31:0] pte_base;
  logic [31:0] ring_asids;
  logic        xl_req;
  logic [31:0] xl_vaddr;
  logic        xl_hit;
  logic        xl_read_ok;
  logic [31:0] xl_paddr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_resp_valid;
  logic        mem_resp_err;
  logic [31:0] mem_rdata;
  logic        busy, done, fail, refill_we, refill_is_fetch;
  logic [1:0]  refill_way;
  logic [1:0]  refill_index;
  logic [31:0] refill_vpn, refill_ppn, fault_vaddr;
  logic [7:0]  refill_asid;
  logic [3:0]  refill_attr;

  int n_chk  = 0;
  int n_fail = 0;
  logic [1:0]  exp_ctr = 2'd0;
  logic [31:0] exp_fault = 32'h0;
  logic        finished = 1'b0;

  always #2.5 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_is_fetch(miss_is_fetch),
    .pte_base(pte_base), .ring_asids(ring_asids),
    .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_hit(xl_hit), .xl_read_ok(xl_read_ok),
    .xl_paddr(xl_paddr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_resp_valid(mem_resp_valid),
    .mem_resp_err(mem_resp_err), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .fail(fail), .refill_we(refill_we),
    .refill_is_fetch(refill_is_fetch), .refill_way(refill_way), .refill_index(refill_index),
    .refill_vpn(refill_vpn), .refill_ppn(refill_ppn), .refill_asid(refill_asid),
    .refill_attr(refill_attr), .fault_vaddr(fault_vaddr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // One complete walk; starts and ends at a falling edge with the walker idle.
  task automatic walk(input logic [31:0] va, input logic fetch, input logic hit,
                      input logic rok, input logic err, input logic [31:0] pte,
                      input int lat, input logic [31:0] xpa, input bit noise);
    logic [31:0] exp_pva;
    logic [1:0]  ring;
    exp_pva = (pte_base | (va >> 10)) & 32'hFFFF_FFFC;
    miss_valid = 1'b1; miss_vaddr = va; miss_is_fetch = fetch;
    xl_hit = hit; xl_read_ok = rok; xl_paddr = xpa;
    @(negedge clk);
    // R9: an intruding miss held while busy must not be taken
    miss_valid = noise; miss_vaddr = ~va; miss_is_fetch = ~fetch;
    chk_eq("R10 busy after accept", {31'b0, busy}, 32'd1);
    chk_eq("R2 lookup request", {31'b0, xl_req}, 32'd1);
    chk_eq("R2 entry address", xl_vaddr, exp_pva);
    @(negedge clk);
    if (!(hit && rok)) begin
      chk_eq("R3 fail pulse", {31'b0, fail}, 32'd1);
      chk_eq("R3 no memory request", {31'b0, mem_req}, 32'd0);
      chk_eq("R3 no further lookup", {31'b0, xl_req}, 32'd0);
      chk_eq("R9 busy low after fail", {31'b0, busy}, 32'd0);
      miss_valid = 1'b0;
      @(negedge clk);
      chk_eq("R3 fail one cycle", {31'b0, fail}, 32'd0);
      chk_eq("R8 fault kept after fail", fault_vaddr, exp_fault);
      return;
    end
    chk_eq("R4 request issued", {31'b0, mem_req}, 32'd1);
    chk_eq("R4 request address", mem_addr, xpa);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      chk_eq("R4 request single cycle", {31'b0, mem_req}, 32'd0);
      chk_eq("R10 busy while waiting", {31'b0, busy}, 32'd1);
    end
    mem_resp_valid = 1'b1; mem_resp_err = err; mem_rdata = pte;
    @(negedge clk);
    mem_resp_valid = 1'b0; mem_resp_err = 1'b0; mem_rdata = 32'hDEAD_BEEF;
    chk_eq("R4 no second request", {31'b0, mem_req}, 32'd0);
    if (err) begin
      chk_eq("R5 fail on error", {31'b0, fail}, 32'd1);
      chk_eq("R5 no refill", {31'b0, refill_we}, 32'd0);
      miss_valid = 1'b0;
      @(negedge clk);
      chk_eq("R8 fault kept after error", fault_vaddr, exp_fault);
      return;
    end
    exp_ctr = exp_ctr + 2'd1;
    ring = pte[5:4];
    chk_eq("R6 refill strobe", {31'b0, refill_we}, 32'd1);
    chk_eq("R6 done", {31'b0, done}, 32'd1);
    chk_eq("R6 no fail", {31'b0, fail}, 32'd0);
    chk_eq("R7 way", {30'b0, refill_way}, {30'b0, exp_ctr});
    chk_eq("R6 vpn", refill_vpn, va & 32'hFFFF_F000);
    chk_eq("R6 index", {30'b0, refill_index}, {30'b0, va[13:12]});
    chk_eq("R6 ppn", refill_ppn, pte & 32'hFFFF_F000);
    chk_eq("R6 attr", {28'b0, refill_attr}, {28'b0, pte[3:0]});
    chk_eq("R6 asid", {24'b0, refill_asid}, {24'b0, ring_asids[8*ring +: 8]});
    chk_eq("R6 access type", {31'b0, refill_is_fetch}, {31'b0, fetch});
    @(negedge clk);
    miss_valid = 1'b0;
    exp_fault = va;
    chk_eq("R9 intruder ignored in write cycle", {31'b0, busy}, 32'd0);
    chk_eq("R8 fault address", fault_vaddr, va);
    chk_eq("R6 strobe one cycle", {31'b0, refill_we}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; miss_valid = 1'b0; miss_vaddr = '0; miss_is_fetch = 1'b0;
    pte_base = 32'hC000_0000; ring_asids = 32'h4433_2211;
    xl_hit = 1'b0; xl_read_ok = 1'b0; xl_paddr = '0;
    mem_resp_valid = 1'b0; mem_resp_err = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 busy", {31'b0, busy}, 32'd0);
    chk_eq("R1 done", {31'b0, done}, 32'd0);
    chk_eq("R1 fail", {31'b0, fail}, 32'd0);
    chk_eq("R1 refill_we", {31'b0, refill_we}, 32'd0);
    chk_eq("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk_eq("R1 fault_vaddr", fault_vaddr, 32'h0);

    for (int i = 0; i < 96; i++) begin
      logic [31:0] va, pte, xpa;
      logic hit, rok, err;
      va  = (32'(i) * 32'h0913_7AB5) ^ 32'hA5A5_0000;
      pte = ((va * 3) & 32'hFFFF_F000) | (32'((i * 7) & 63) << 6)
            | (32'((i >> 1) & 3) << 4) | 32'(i & 15);
      xpa = 32'h0008_0000 | (32'(i) << 2);
      hit = (i % 7 != 3);
      rok = (i % 7 != 5);
      err = (i % 11 == 4);
      pte_base   = 32'hC000_0000 | (32'(i & 15) << 24) | 32'(i & 3);
      ring_asids = {8'(i + 4), 8'(i + 3), 8'(i + 2), 8'(i + 1)};
      walk(va, i[0], hit, rok, err, pte, i % 3, xpa, (i % 5) == 0);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule